// File: doc/BRIEF.md
# Diminished-One Modulo 2^n+1 Multiplier

This block multiplies two residues modulo 2^n+1 and returns their product in the same residue form. Every operand and the result use a diminished-one code. The top bit is a zero flag. When the flag is clear, the low n bits hold the value minus one. This code lets every residue from 0 to 2^n pass through an n-bit datapath. The block is meant for the modulo 2^n+1 channel of a residue-number arithmetic unit, for example in filters and transforms.

The multiplier A is recoded into radix-4 signed digits. The recoding works on the stored code of A with an implicit low bit of one, so the digits add up to A itself. Each digit picks zero, the multiplicand, or twice the multiplicand, and may negate it. In this code, doubling is a left rotation that inverts the bit that wraps, and negation is a bitwise NOT. One more row cancels the weight of the top code bit, and one correction row is formed from a count of empty rows. A carry-save array with inverted end-around carries reduces all rows to a pair. A diminished-one modulo adder then produces the result. The output can be registered (one cycle) or taken combinationally.

Top module: `dm1_mulmod`

## Requirements
- R1: Bit n of each operand and of the result is the zero flag (1 means the residue 0), and bits n-1:0 hold X-1 for a nonzero residue X. The result is the code of A*B mod 2^n+1 for every pair of residues in 0..2^n.
- R2: When either operand has its zero flag set, the result is the zero code (flag 1, value bits 0), whatever the operands' value bits hold.
- R3: A product that is congruent to 0 while both operands are nonzero is possible only for a composite modulus, for example n=6 with 5*13 mod 65. Such a product gives the zero code.
- R4: With OUT_REG=1 the result of the operands present at a rising clock edge appears after that edge. While rst_n is low, the output holds the zero code.
- R5: Exactly n/2+2 rows enter the reduction: n/2 radix-4 digit rows from one shared recoder, one row for the top code bit of A, and one correction row equal to the bitwise NOT of the count of empty rows. Products are correct when the digits take each value from -2 to +2 at every position.
- R6: A multiplier code of all zeros (residue 1) returns the multiplicand's code unchanged.
- R7: A multiplier code with flag 0 and all value bits one (residue 2^n, which is -1) returns flag 0 and the bitwise inverse of the multiplicand's value bits.
- R8: Each carry-save stage and the final adder complement the carry out of bit n-1 and feed it into bit 0. Each carry-save stage therefore keeps its sum congruent to its inputs plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| op_a | input | N+1 | Multiplier: zero flag in bit N, diminished value below it |
| op_b | input | N+1 | Multiplicand: zero flag in bit N, diminished value below it |
| prod | output | N+1 | Product code in the same format |

## Verification
The operand pairs are drawn from a corner set: 0, 1, 2, 3, 2^n-1, 2^n, the midpoint and one arbitrary value. These pairs separate the flag path, the identity and negation cases, and the end-around wrap at both ends of the range. Multiplier codes made of alternating bit pairs drive every digit to +2, -2, +1, -1 and 0 at every position, which exposes any fault in the recoder or the rotation. Random pairs cover the bulk of the range. A second instance with n=6 is run over all 65*65 operand pairs, which covers every product that is zero through a factor of 5 or 13. It also checks the correction count at a second width.

// File: rtl/dm1_mul_pkg.sv
`timescale 1ns/1ps
package dm1_mul_pkg;

  // Signed radix-4 digit, one-hot magnitude with sign
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_dig_t;

  // Shared recoder: triple is {upper, middle, lower} overlapping bits
  function automatic booth_dig_t booth_decode(input logic [2:0] trip);
    booth_dig_t d;
    d.neg = trip[2];
    d.one = trip[1] ^ trip[0];
    d.two = (trip[2] & ~trip[1] & ~trip[0]) | (~trip[2] & trip[1] & trip[0]);
    return d;
  endfunction

endpackage

// File: rtl/dm1_booth_row.sv
`timescale 1ns/1ps
module dm1_booth_row
  import dm1_mul_pkg::*;
#(
  parameter int N   = 16,
  parameter int POS = 0
) (
  input  logic [2:0]   trip,
  input  logic [N-1:0] mcand,
  output logic [N-1:0] row,
  output logic         row_zero
);

  localparam int SH1 = 2 * POS;
  localparam int SH2 = 2 * POS + 1;

  logic [N-1:0] rot1;
  logic [N-1:0] rot2;
  logic [N-1:0] pick;
  booth_dig_t   dig;

  // Diminished-one scaling by 2^k: rotate left, inverting wrapped bits
  for (genvar j = 0; j < N; j++) begin : g_rot
    if (j >= SH1) begin : g_k1
      assign rot1[j] = mcand[j-SH1];
    end else begin : g_w1
      assign rot1[j] = ~mcand[N-SH1+j];
    end
    if (j >= SH2) begin : g_k2
      assign rot2[j] = mcand[j-SH2];
    end else begin : g_w2
      assign rot2[j] = ~mcand[N-SH2+j];
    end
  end

  always_comb begin
    dig      = booth_decode(trip);
    pick     = dig.two ? rot2 : rot1;
    row_zero = ~(dig.one | dig.two);
    row      = row_zero ? '0 : (dig.neg ? ~pick : pick);
  end

  function automatic bit row_ok(input logic [2:0] t, input logic [N-1:0] v,
                                input logic [N-1:0] r, input logic z);
    longint m, d, want, got;
    m    = (longint'(1) << N) + 1;
    d    = longint'(t[1]) + longint'(t[0]) - 2 * longint'(t[2]);
    want = ((d * (longint'(1) << (2 * POS))) % m) * ((longint'(v) + 1) % m);
    want = ((want % m) + m) % m;
    got  = z ? 0 : (longint'(r) + 1) % m;
    return want == got;
  endfunction

  always_comb begin
    if (!$isunknown({trip, mcand})) begin
      // R5
      booth_row_value_chk: assert (row_ok(trip, mcand, row, row_zero))
        else $error("booth row residue mismatch at digit %0d", POS);
    end
  end

endmodule

// File: rtl/dm1_csa.sv
`timescale 1ns/1ps
module dm1_csa #(
  parameter int N = 16
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic [N-1:0] z,
  output logic [N-1:0] s,
  output logic [N-1:0] c_wrap
);

  logic [N-1:0] maj;

  always_comb begin
    s      = x ^ y ^ z;
    maj    = (x & y) | (x & z) | (y & z);
    c_wrap = {maj[N-2:0], ~maj[N-1]};
  end

  function automatic bit csa_ok(input logic [N-1:0] a, input logic [N-1:0] b,
                                input logic [N-1:0] e, input logic [N-1:0] so,
                                input logic [N-1:0] co);
    longint m;
    m = (longint'(1) << N) + 1;
    return ((longint'(so) + longint'(co)) % m) ==
           ((longint'(a) + longint'(b) + longint'(e) + 1) % m);
  endfunction

  always_comb begin
    if (!$isunknown({x, y, z})) begin
      // R8
      csa_congruent_chk: assert (csa_ok(x, y, z, s, c_wrap))
        else $error("carry-save stage lost its residue");
    end
  end

endmodule

// File: rtl/dm1_final_add.sv
`timescale 1ns/1ps
module dm1_final_add #(
  parameter int N = 16
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N-1:0] sum,
  output logic         sum_zero
);

  logic [N:0] t;
  logic [N:0] u;

  always_comb begin
    t        = {1'b0, x} + {1'b0, y} + (N+1)'(1);
    u        = {1'b0, t[N-1:0]} + {{N{1'b0}}, ~t[N]};
    sum_zero = u[N];
    sum      = u[N-1:0];
  end

  function automatic bit fin_ok(input logic [N-1:0] a, input logic [N-1:0] b,
                                input logic [N:0] r);
    longint m;
    m = (longint'(1) << N) + 1;
    return (r <= (N+1)'(1 << N)) &&
           ((longint'(r) % m) == ((longint'(a) + longint'(b) + 2) % m));
  endfunction

  always_comb begin
    if (!$isunknown({x, y})) begin
      // R8
      final_congruent_chk: assert (fin_ok(x, y, u))
        else $error("final adder residue mismatch");
    end
  end

endmodule

// File: rtl/dm1_mulmod.sv
`timescale 1ns/1ps
module dm1_mulmod
  import dm1_mul_pkg::*;
#(
  parameter int N       = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [N:0] op_a,
  input  logic [N:0] op_b,
  output logic [N:0] prod
);

  localparam int DIGS   = N / 2;
  localparam int ROWS   = DIGS + 2;
  localparam int STAGES = ROWS - 2;
  localparam int CNTW   = $clog2(DIGS + 2);

  logic [N-1:0]  a_v, b_v;
  logic          a_z, b_z;
  logic [N-1:0]  rows [ROWS];
  logic [DIGS:0] empty;
  logic [CNTW-1:0] n_empty;
  logic [N-1:0]  st_s [STAGES];
  logic [N-1:0]  st_c [STAGES];
  logic [N-1:0]  f_val;
  logic          f_zero;
  logic [N:0]    prod_d;

  assign a_z = op_a[N];
  assign b_z = op_b[N];
  assign a_v = op_a[N-1:0];
  assign b_v = op_b[N-1:0];

  // Digit rows: implicit low bit 1 makes the digits sum to the residue itself
  for (genvar i = 0; i < DIGS; i++) begin : g_dig
    logic [2:0] trip;
    if (i == 0) begin : g_lsd
      assign trip = {a_v[1], a_v[0], 1'b1};
    end else begin : g_mid
      assign trip = {a_v[2*i+1], a_v[2*i], a_v[2*i-1]};
    end
    dm1_booth_row #(.N(N), .POS(i)) u_row (
      .trip     (trip),
      .mcand    (b_v),
      .row      (rows[i]),
      .row_zero (empty[i])
    );
  end

  // Weight 2^n of the top code bit folds to -1: subtract the multiplicand
  assign rows[DIGS]  = a_v[N-1] ? ~b_v : '0;
  assign empty[DIGS] = ~a_v[N-1];

  always_comb begin
    n_empty = '0;
    for (int i = 0; i <= DIGS; i++) begin
      n_empty = n_empty + CNTW'(empty[i]);
    end
  end

  assign rows[ROWS-1] = ~(N'(n_empty));

  // Carry-save array, one new row per stage
  for (genvar j = 0; j < STAGES; j++) begin : g_csa
    if (j == 0) begin : g_first
      dm1_csa #(.N(N)) u_csa (
        .x (rows[0]), .y (rows[1]), .z (rows[2]),
        .s (st_s[0]), .c_wrap (st_c[0])
      );
    end else begin : g_next
      dm1_csa #(.N(N)) u_csa (
        .x (st_s[j-1]), .y (st_c[j-1]), .z (rows[j+2]),
        .s (st_s[j]), .c_wrap (st_c[j])
      );
    end
  end

  dm1_final_add #(.N(N)) u_fin (
    .x        (st_s[STAGES-1]),
    .y        (st_c[STAGES-1]),
    .sum      (f_val),
    .sum_zero (f_zero)
  );

  always_comb begin
    if (a_z || b_z || f_zero) prod_d = {1'b1, {N{1'b0}}};
    else                      prod_d = {1'b0, f_val};
  end

  if (OUT_REG) begin : g_reg
    logic [N:0] prod_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod_q <= {1'b1, {N{1'b0}}};
      else        prod_q <= prod_d;
    end

    assign prod = prod_q;

    // R2
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_a[N] || op_b[N]) |=> (prod == {1'b1, {N{1'b0}}}))
      else $error("zero operand did not give zero code");

    // R6
    unit_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_a == '0) && !op_b[N]) |=> (prod == $past(op_b)))
      else $error("residue 1 multiplier changed the multiplicand");

    // R7
    neg_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_a == {1'b0, {N{1'b1}}}) && !op_b[N])
        |=> (prod == {1'b0, ~$past(op_b[N-1:0])}))
      else $error("residue -1 multiplier did not negate");
  end else begin : g_comb
    assign prod = prod_d;
  end

endmodule

// File: tb/dm1_mulmod_tb_top.sv
`timescale 1ns/1ps
module dm1_mulmod_tb_top;

  localparam int NW = 16;
  localparam int NS = 6;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic [NW:0] a16, b16;
  logic [NW:0] p16;
  logic [NS:0] a6, b6;
  logic [NS:0] p6;

  dm1_mulmod #(.N(NW), .OUT_REG(1'b1)) dut_i (
    .clk (clk), .rst_n (rst_n), .op_a (a16), .op_b (b16), .prod (p16)
  );

  dm1_mulmod #(.N(NS), .OUT_REG(1'b1)) dut_n6_i (
    .clk (clk), .rst_n (rst_n), .op_a (a6), .op_b (b6), .prod (p6)
  );

  logic [NW:0] q16_exp[$];
  string       q16_tag[$];
  logic [NW:0] q6_exp[$];
  string       q6_tag[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  function automatic logic [NW:0] enc(input int n, input longint x);
    logic [NW:0] r;
    r = '0;
    if (x == 0) r[n] = 1'b1;
    else        r = (NW+1)'(x - 1);
    return r;
  endfunction

  function automatic logic [NW:0] refp(input int n, input longint x, input longint y);
    longint m;
    m = (longint'(1) << n) + 1;
    return enc(n, (x * y) % m);
  endfunction

  task automatic chk(input string tag, input logic [NW:0] got, input logic [NW:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic drive16(input logic [NW:0] ea, input logic [NW:0] eb,
                         input logic [NW:0] ex, input string tag);
    @(negedge clk);
    a16 = ea;
    b16 = eb;
    q16_exp.push_back(ex);
    q16_tag.push_back(tag);
  endtask

  task automatic pair16(input longint x, input longint y, input string tag);
    drive16(enc(NW, x), enc(NW, y), refp(NW, x, y), tag);
  endtask

  task automatic pair6(input longint x, input longint y, input string tag);
    logic [NW:0] ea, eb;
    ea = enc(NS, x);
    eb = enc(NS, y);
    @(negedge clk);
    a6 = ea[NS:0];
    b6 = eb[NS:0];
    q6_exp.push_back(refp(NS, x, y));
    q6_tag.push_back(tag);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Monitors: one registered stage, sampled 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q16_exp.size() > 0) chk(q16_tag.pop_front(), p16, q16_exp.pop_front());
      if (q6_exp.size() > 0)  chk(q6_tag.pop_front(), {{(NW-NS){1'b0}}, p6}, q6_exp.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R4 watchdog got=timeout exp=completion");
      finish_run();
    end
  end

  initial begin
    longint cv[8];
    logic [15:0] pats[8];
    rst_n = 1'b0;
    a16 = '0; b16 = '0; a6 = '0; b6 = '0;
    cv = '{0, 1, 2, 3, 65535, 65536, 32768, 12345};
    pats = '{16'hAAAA, 16'h5555, 16'hCCCC, 16'h3333,
             16'h6666, 16'h9999, 16'h8000, 16'h7FFF};

    repeat (3) @(negedge clk);
    // R4: zero code held in reset
    chk("R4 reset", p16, 17'h10000);
    chk("R4 reset", {{(NW-NS){1'b0}}, p6}, 17'h00040);
    @(negedge clk);
    rst_n = 1'b1;

    // Corner residues, all ordered pairs
    foreach (cv[i]) begin
      foreach (cv[k]) begin
        if (cv[i] == 0 || cv[k] == 0) pair16(cv[i], cv[k], "R2");
        else if (cv[i] == 1)          pair16(cv[i], cv[k], "R6");
        else if (cv[i] == 65536)      pair16(cv[i], cv[k], "R7");
        else                          pair16(cv[i], cv[k], "R1");
      end
    end

    // R2: value bits under a set zero flag are ignored
    drive16({1'b1, 16'h1234}, enc(NW, 77), 17'h10000, "R2");
    drive16(enc(NW, 65536), {1'b1, 16'hFFFF}, 17'h10000, "R2");
    drive16({1'b1, 16'h8001}, {1'b1, 16'h0F0F}, 17'h10000, "R2");

    // R5: every digit value at every position
    foreach (pats[i]) begin
      for (int k = 0; k < 4; k++) begin
        pair16(longint'(pats[i]) + 1, longint'($urandom % 65536) + 1, "R5");
      end
    end

    for (int k = 0; k < 300; k++) begin
      pair16(longint'($urandom % 65537), longint'($urandom % 65537), "R1 R8");
    end

    // Composite modulus 65: exhaustive
    for (int x = 0; x <= 64; x++) begin
      for (int y = 0; y <= 64; y++) begin
        if (x != 0 && y != 0 && ((x * y) % 65) == 0) pair6(x, y, "R3");
        else                                         pair6(x, y, "R1");
      end
    end

    repeat (4) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule